// File: doc/BRIEF.md
# Conversion clock divider with periodic queue triggers

This block derives the conversion-clock timing of a successive-approximation converter from the system clock. A programmable ratio register sets how many system cycles make up one conversion-clock period. Each period yields a one-cycle enable pulse on `qclk_en`, plus a level `qclk_div` that is high for the first half of the period. The ratio is the stored value plus one, except that a stored zero gives a ratio of two. No setting can make the conversion clock faster than half the system clock.

Changing the ratio while a conversion is running would corrupt that conversion. For this reason a register write is refused while any conversion queue reports itself enabled. A write is also refused when its value is out of range. Each refused write sets a sticky error flag, which stays set until it is cleared.

A free-running 17-bit binary counter advances once per conversion-clock pulse. Both queues share this counter. Each queue has a 4-bit rate code that selects one counter tap. When that tap falls from 1 to 0, the queue gets a single-cycle trigger pulse. This gives trigger periods of 2^7 to 2^17 conversion-clock cycles.

Top module: `adc_clk_trig`

## Requirements
- R1: A written value P in 1..39 gives a conversion-clock period of P+1 system cycles. `qclk_en` is high for exactly one cycle per period, so the spacing between pulses is P+1.
- R2: A stored value of 0 gives a period of 2 system cycles. After reset the stored value is 0.
- R3: A write with a value above 39 is ignored, the period does not change, and `wr_err` is set.
- R4: `qclk_en` is never high in two consecutive cycles.
- R5: An accepted write never shortens or splits the period that is running. A write accepted in the cycle where `qclk_en` is high leaves the following period at the old ratio, and the new ratio starts with the period after that.
- R6: A write while any bit of `q_enabled` is 1 is ignored, the period does not change, and `wr_err` is set.
- R7: `wr_err` stays high until `err_clr` is 1. If a refused write and `err_clr` fall in the same cycle, `wr_err` stays set.
- R8: `qclk_div` is high for the first ceil(N/2) system cycles of each period of N cycles and low for the rest. The spacing between `qclk_en` pulses contains exactly that many high cycles.
- R9: A shared 17-bit counter, cleared by reset, advances by one on each `qclk_en`. For a queue with rate code c (0..10, on its 4-bit field, queue i at bits 4i+3..4i), let k = c+7. The queue's `q_trig` bit is high for exactly one cycle: the cycle after a `qclk_en` that takes the counter from a value whose low k bits are all ones. The trigger period is therefore 2^k pulses.
- R10: Rate codes 11..15 produce no trigger on that queue.
- R11: Reset is synchronous and active high. It clears the divider and the shared counter, sets the stored value to 0, and holds `q_trig` and `wr_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_wr | input | 1 | Ratio register write strobe |
| pre_wdata | input | 6 | Ratio register write value |
| err_clr | input | 1 | Clears the refused-write flag |
| q_enabled | input | 2 | Per-queue enabled status; any 1 locks the ratio |
| q_rate | input | 8 | Per-queue 4-bit rate codes, queue i at bits 4i+3..4i |
| qclk_en | output | 1 | One-cycle conversion-clock enable |
| qclk_div | output | 1 | Divided clock level, high in the first half of each period |
| q_trig | output | 2 | Per-queue one-cycle trigger pulses |
| wr_err | output | 1 | Sticky refused-write flag |

## Verification
Two pairs of functions can land in the same cycle. The first is a ratio write and the divider's wrap, where the new ratio is loaded. The driver provokes this by issuing the write on the very cycle a conversion-clock pulse is seen. The scoreboard then expects the old ratio for the next period and the new one only after that, and compares each measured spacing and high-level count. The second is a refused write and an error clear in the same cycle; here the flag must read as set afterwards.

// File: rtl/adct_pkg.sv
package adct_pkg;
  localparam int PRE_W     = 6;
  localparam int PRE_MAX   = 39;
  localparam int DIV_W     = $clog2(PRE_MAX + 2);
  localparam int RATE_W    = 4;
  localparam int TAP_BASE  = 7;
  localparam int TAP_COUNT = 11;
  localparam int CNT_W     = TAP_BASE + TAP_COUNT - 1;

  // divide ratio produced by a stored register value
  function automatic logic [DIV_W-1:0] ratio_of(input logic [PRE_W-1:0] p);
    if (p == '0) return DIV_W'(2);
    return DIV_W'(p) + DIV_W'(1);
  endfunction

  // number of high cycles of the divided level within one period
  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] n);
    return DIV_W'((32'(n) + 32'd1) >> 1);
  endfunction

  // true when the low k bits of c are all ones
  function automatic logic ripple_at(input logic [CNT_W-1:0] c, input int k);
    logic r;
    r = 1'b1;
    for (int i = 0; i < CNT_W; i++)
      if (i < k && !c[i]) r = 1'b0;
    return r;
  endfunction

  function automatic logic rate_valid(input logic [RATE_W-1:0] code);
    return int'(code) < TAP_COUNT;
  endfunction
endpackage

// File: rtl/adct_prescale_reg.sv
module adct_prescale_reg
  import adct_pkg::*;
#(
  parameter int W   = PRE_W,
  parameter int MAX = PRE_MAX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         busy,
  input  logic         err_clr,
  output logic [W-1:0] stored,
  output logic         err
);
  logic         wr_ok;
  logic         wr_bad;
  logic [W-1:0] stored_q;
  logic         err_q;

  assign wr_ok  = wr && !busy && (int'(wdata) <= MAX);
  assign wr_bad = wr && !wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr_ok) stored_q <= wdata;
      if (wr_bad)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign stored = stored_q;
  assign err    = err_q;

  a_r6_blocked_hold: assert property (@(posedge clk) disable iff (rst)
    (wr && busy) |=> $stable(stored_q));
  a_r3_range_flag: assert property (@(posedge clk) disable iff (rst)
    (wr && int'(wdata) > MAX) |=> (err_q && $stable(stored_q)));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/adct_divider.sv
module adct_divider
  import adct_pkg::*;
#(
  parameter int W  = PRE_W,
  parameter int DW = DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stored,
  output logic         tick,
  output logic         level
);
  logic [DW-1:0] phase_q;
  logic [DW-1:0] ratio_q;
  logic          wrap;

  assign wrap = (phase_q == ratio_q - DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      ratio_q <= ratio_of('0);
    end else if (wrap) begin
      phase_q <= '0;
      ratio_q <= ratio_of(stored);
    end else begin
      phase_q <= phase_q + DW'(1);
    end
  end

  assign tick  = wrap && !rst;
  assign level = (phase_q < high_len(ratio_q));

  a_r4_no_double_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r5_ratio_hold: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(ratio_q));
  a_r2_ratio_floor: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= DW'(2));
endmodule

// File: rtl/adct_tick_counter.sv
module adct_tick_counter
  import adct_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [CW-1:0] count
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + CW'(1);
  end

  assign count = count_q;

  a_r9_count_idle: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/adct_qtrig.sv
module adct_qtrig
  import adct_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic [RW-1:0] rate,
  output logic          trig
);
  logic fire;
  logic trig_q;

  assign fire = tick && rate_valid(rate) && ripple_at(count, TAP_BASE + int'(rate));

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= fire;
  end

  assign trig = trig_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_q |=> !trig_q);
  a_r9_follows_tick: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> $past(tick));
  a_r10_code_off: assert property (@(posedge clk) disable iff (rst)
    !rate_valid(rate) |=> !trig_q);
endmodule

// File: rtl/adc_clk_trig.sv
module adc_clk_trig
  import adct_pkg::*;
#(
  parameter int NQ = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pre_wr,
  input  logic [PRE_W-1:0]     pre_wdata,
  input  logic                 err_clr,
  input  logic [NQ-1:0]        q_enabled,
  input  logic [NQ*RATE_W-1:0] q_rate,
  output logic                 qclk_en,
  output logic                 qclk_div,
  output logic [NQ-1:0]        q_trig,
  output logic                 wr_err
);
  logic [PRE_W-1:0] stored;
  logic [CNT_W-1:0] count;
  logic             busy;

  assign busy = |q_enabled;

  adct_prescale_reg u_reg (
    .clk(clk), .rst(rst), .wr(pre_wr), .wdata(pre_wdata), .busy(busy),
    .err_clr(err_clr), .stored(stored), .err(wr_err)
  );

  adct_divider u_div (
    .clk(clk), .rst(rst), .stored(stored), .tick(qclk_en), .level(qclk_div)
  );

  adct_tick_counter u_cnt (
    .clk(clk), .rst(rst), .tick(qclk_en), .count(count)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    adct_qtrig u_trig (
      .clk(clk), .rst(rst), .tick(qclk_en), .count(count),
      .rate(q_rate[q*RATE_W +: RATE_W]), .trig(q_trig[q])
    );
  end

  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_trig == '0 && !wr_err));
endmodule

// File: tb/adc_clk_trig_test.sv
module adc_clk_trig_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre_wr = 1'b0;
  logic [5:0] pre_wdata = '0;
  logic       err_clr = 1'b0;
  logic [1:0] q_enabled = '0;
  logic [7:0] q_rate = 8'hFF;
  logic       qclk_en, qclk_div, wr_err;
  logic [1:0] q_trig;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int cur_n = 2;
  int exp_q[$];
  string tag_q[$];
  int seen_trig[2];
  logic done = 1'b0;

  adc_clk_trig uut (
    .clk(clk), .rst(rst), .pre_wr(pre_wr), .pre_wdata(pre_wdata),
    .err_clr(err_clr), .q_enabled(q_enabled), .q_rate(q_rate),
    .qclk_en(qclk_en), .qclk_div(qclk_div), .q_trig(q_trig), .wr_err(wr_err)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // scoreboard monitor: period spacing, high count, trigger prediction
  int last_en = -1;
  int hi_cnt = 0;
  int bcnt = 0;
  logic [1:0] trig_exp = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      last_en = -1; hi_cnt = 0; bcnt = 0; trig_exp = '0;
    end else begin
      for (int q = 0; q < 2; q++) begin
        if (q_trig[q] !== trig_exp[q])
          check($sformatf("R9 trigger queue %0d at cycle %0d", q, cyc), int'(q_trig[q]), int'(trig_exp[q]));
        else if (trig_exp[q]) begin
          checks++;
          seen_trig[q]++;
        end
      end
      for (int q = 0; q < 2; q++) begin
        int code;
        code = int'(q_rate[q*4 +: 4]);
        trig_exp[q] = qclk_en && code <= 10 && (((bcnt + 1) % (1 << (code + 7))) == 0);
      end
      if (qclk_div) hi_cnt++;
      if (qclk_en) begin
        if (last_en >= 0 && exp_q.size() > 0) begin
          int n;
          string t;
          n = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " period"}, cyc - last_en, n);
          check({"R8 high cycles ", t}, hi_cnt, (n + 1) / 2);
        end
        last_en = cyc;
        hi_cnt = 0;
        bcnt++;
      end
    end
  end

  // driver: write aligned to a conversion-clock pulse, push expected periods
  task automatic write_aligned(input int val, input logic accept, input string tag);
    int nxt;
    do @(negedge clk); while (!qclk_en);
    #2;
    pre_wr = 1'b1;
    pre_wdata = 6'(val);
    nxt = accept ? ((val == 0) ? 2 : val + 1) : cur_n;
    exp_q.push_back(cur_n); tag_q.push_back({tag, " (R5 old ratio)"});
    exp_q.push_back(nxt);   tag_q.push_back(tag);
    exp_q.push_back(nxt);   tag_q.push_back(tag);
    @(posedge clk); #2;
    pre_wr = 1'b0;
    cur_n = nxt;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic clear_err();
    @(posedge clk); #2 err_clr = 1'b1;
    @(posedge clk); #2 err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check("R11 reset qclk_en", int'(qclk_en), 0);
    check("R11 reset q_trig", int'(q_trig), 0);
    check("R11 reset wr_err", int'(wr_err), 0);

    write_aligned(0, 1'b1, "R2 default ratio 2");
    write_aligned(5, 1'b1, "R1 ratio 6");
    write_aligned(39, 1'b1, "R1 ratio 40");
    write_aligned(1, 1'b1, "R1 ratio 2");
    write_aligned(0, 1'b1, "R2 zero gives 2");
    write_aligned(4, 1'b1, "R1 ratio 5 (R4)");
    check("R3 no flag yet", int'(wr_err), 0);

    write_aligned(45, 1'b0, "R3 out of range kept");
    check("R3 flag set", int'(wr_err), 1);
    repeat (5) @(negedge clk);
    check("R7 flag sticky", int'(wr_err), 1);
    clear_err();
    check("R7 flag cleared", int'(wr_err), 0);

    @(posedge clk); #2 q_enabled = 2'b01;
    write_aligned(9, 1'b0, "R6 locked queue0");
    check("R6 flag set", int'(wr_err), 1);
    clear_err();
    @(posedge clk); #2 q_enabled = 2'b10;
    write_aligned(2, 1'b0, "R6 locked queue1");
    check("R6 flag set queue1", int'(wr_err), 1);
    clear_err();

    // refused write and clear in the same cycle
    @(posedge clk); #2;
    pre_wr = 1'b1; pre_wdata = 6'd7; err_clr = 1'b1;
    @(posedge clk); #2;
    pre_wr = 1'b0; err_clr = 1'b0;
    @(negedge clk);
    check("R7 set wins over clear", int'(wr_err), 1);
    clear_err();
    @(posedge clk); #2 q_enabled = 2'b00;

    write_aligned(1, 1'b1, "R1 ratio 2 for triggers");
    @(posedge clk); #2 q_rate = {4'd1, 4'd0};
    repeat (1200) @(posedge clk);
    check("R9 queue0 code0 fired", int'(seen_trig[0] > 0), 1);
    check("R9 queue1 code1 fired", int'(seen_trig[1] > 0), 1);
    #2 q_rate = {4'd12, 4'd3};
    seen_trig[1] = 0;
    seen_trig[0] = 0;
    repeat (4500) @(posedge clk);
    check("R10 queue1 code12 silent", seen_trig[1], 0);
    check("R9 queue0 code3 fired", int'(seen_trig[0] > 0), 1);
    #2 q_rate = {4'd15, 4'd11};
    repeat (600) @(posedge clk);
    @(negedge clk);
    check("R10 codes 11 and 15 silent", int'(q_trig), 0);

    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk);
    check("R11 trig low after reset", int'(q_trig), 0);
    check("R11 enable low after reset", int'(qclk_en), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule